// File: doc/BRIEF.md
# Ethernet DMA Interrupt Status Register

This block holds the interrupt status word of an Ethernet DMA engine. The receive and transmit DMA state machines and the bus interface send it single-cycle event pulses. It keeps each event as a sticky flag until the host clears it through a plain read/write register port.

The block also tracks the state of the receive process: stopped, running or suspended. It counts the bytes of each incoming frame and flags frames that are too long. After a fatal bus error it raises a bus-disable output and keeps the error type. The host reads the whole word combinationally on `host_rdata` and clears flags by writing ones on `host_wdata` with `host_wr` high.

Top module: `dma_irq_status`

## Requirements
- R1: After reset, `host_rdata` reads 0, `rx_state` is 0 (Stopped) and `bus_disable` is 0.
- R2: A host write clears each flag whose `host_wdata` bit is 1, and leaves unchanged each flag whose bit is 0. If a hardware set and a host clear hit the same flag in the same cycle, the flag ends up set.
- R3: `rx_frame_done` sets bit 6 on the next cycle, and `tx_fifo_loaded` sets bit 10 on the next cycle.
- R4: `rx_buf1_full` sets bit 14. Bit 14 is cleared in every cycle in which `rx_frame_done` is high, even when `rx_buf1_full` is high in that same cycle.
- R5: A descriptor fetch (`rx_desc_fetch`) while Running with `rx_desc_dma_owned`=0 moves `rx_state` to 2 (Suspended). It sets bit 7 only if the previous fetch seen while Running was DMA-owned. After reset, the previous fetch counts as DMA-owned.
- R6: In Suspended, `rx_poll_demand` or `rx_frame_start` returns `rx_state` to 1 (Running).
- R7: `rx_start` moves Stopped to Running. `rx_stop` moves any state to Stopped and has priority over every other transition. Bit 8 sets only when the process enters Stopped from Running or Suspended. `rx_state` never reads 3.
- R8: Bit 9 sets when the byte count of a frame exceeds STD_LIMIT, or JUMBO_LIMIT when `jumbo_en` is 1. Bytes are counted by `rx_byte_valid` and the count restarts at `rx_frame_start`. Bit 9 sets at most once per frame.
- R9: `bus_err` sets bit 13. Bits 25:23 take `bus_err_code` only at the cycle bit 13 goes from 0 to 1, hold that value while bit 13 stays set, and read 0 once bit 13 is cleared.
- R10: `bus_disable` rises the cycle after `bus_err` and stays high exactly as long as bit 13 is set.
- R11: All bits other than 6 to 10, 13, 14 and 23 to 25 read 0, and writing them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_frame_done | input | 1 | Frame received and status written back |
| rx_buf1_full | input | 1 | First data buffer of a packet filled |
| rx_desc_fetch | input | 1 | Receive descriptor fetched |
| rx_desc_dma_owned | input | 1 | Ownership of the fetched descriptor (1 = DMA) |
| rx_poll_demand | input | 1 | Host receive poll-demand command |
| rx_frame_start | input | 1 | Start of a recognised incoming frame |
| rx_byte_valid | input | 1 | One received byte |
| rx_start | input | 1 | Start the receive process |
| rx_stop | input | 1 | Stop the receive process |
| jumbo_en | input | 1 | Selects the long frame-length limit |
| tx_fifo_loaded | input | 1 | Transmit frame fully moved into the FIFO |
| bus_err | input | 1 | Fatal bus error |
| bus_err_code | input | 3 | Type of the bus error |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data, 1 clears a flag |
| host_rdata | output | 32 | Status word |
| rx_state | output | 2 | 0 Stopped, 1 Running, 2 Suspended |
| bus_disable | output | 1 | Blocks all bus access of the DMA |

## Verification
Two pairs of functions can act on the same bit in one cycle. The first pair is a hardware set with a host write-one clear of the same flag. The second is the early-buffer event arriving together with frame completion, which must clear bit 14. The bench sweeps every combination of prior flag value, event and clear for bits 6, 10 and 14. It predicts each result with a small boolean formula taken from R2 and R4. The frame-length limit is swept over every length up to past the long limit, in both length modes.

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int STD_LIMIT   = 2048,
  parameter int JUMBO_LIMIT = 10240
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_frame_done,
  input  logic        rx_buf1_full,
  input  logic        rx_desc_fetch,
  input  logic        rx_desc_dma_owned,
  input  logic        rx_poll_demand,
  input  logic        rx_frame_start,
  input  logic        rx_byte_valid,
  input  logic        rx_start,
  input  logic        rx_stop,
  input  logic        jumbo_en,
  input  logic        tx_fifo_loaded,
  input  logic        bus_err,
  input  logic [2:0]  bus_err_code,
  input  logic        host_wr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic [1:0]  rx_state,
  output logic        bus_disable
);
  localparam int CW = $clog2(JUMBO_LIMIT + 2);
  localparam logic [CW-1:0] CSAT = CW'(JUMBO_LIMIT + 1);
  localparam logic [CW-1:0] LIM_STD = CW'(STD_LIMIT);
  localparam logic [CW-1:0] LIM_JMB = CW'(JUMBO_LIMIT);

  typedef enum logic [1:0] {ST_STOP = 2'd0, ST_RUN = 2'd1, ST_SUSP = 2'd2} rx_st_e;
  rx_st_e st, st_nxt;

  logic f_ri, f_ru, f_rps, f_rwt, f_eti, f_fbi, f_eri;
  logic [2:0] err_code;
  logic prev_dma;
  logic [CW-1:0] cnt, cnt_nxt;
  logic wd_fired;

  wire [31:0] clr = host_wr ? host_wdata : 32'd0;
  wire running = (st == ST_RUN);
  wire host_desc = running && rx_desc_fetch && !rx_desc_dma_owned && !rx_stop;
  wire set_ru = host_desc && prev_dma;
  wire set_rps = rx_stop && (st != ST_STOP);

  wire [CW-1:0] limit = jumbo_en ? LIM_JMB : LIM_STD;
  wire wd_armed = rx_frame_start ? 1'b0 : wd_fired;
  wire set_rwt = rx_byte_valid && !wd_armed && (cnt_nxt > limit);

  always_comb begin
    if (rx_frame_start) cnt_nxt = rx_byte_valid ? CW'(1) : '0;
    else if (rx_byte_valid && cnt != CSAT) cnt_nxt = cnt + CW'(1);
    else cnt_nxt = cnt;
  end

  always_comb begin
    st_nxt = st;
    if (rx_stop) st_nxt = ST_STOP;
    else case (st)
      ST_STOP: if (rx_start) st_nxt = ST_RUN;
      ST_RUN:  if (host_desc) st_nxt = ST_SUSP;
      ST_SUSP: if (rx_poll_demand || rx_frame_start) st_nxt = ST_RUN;
      default: st_nxt = ST_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_STOP;
      prev_dma <= 1'b1;
      cnt      <= '0;
      wd_fired <= 1'b0;
      f_ri     <= 1'b0;
      f_ru     <= 1'b0;
      f_rps    <= 1'b0;
      f_rwt    <= 1'b0;
      f_eti    <= 1'b0;
      f_fbi    <= 1'b0;
      f_eri    <= 1'b0;
      err_code <= 3'd0;
    end else begin
      st       <= st_nxt;
      if (running && rx_desc_fetch) prev_dma <= rx_desc_dma_owned;
      cnt      <= cnt_nxt;
      wd_fired <= wd_armed | set_rwt;
      f_ri     <= rx_frame_done  | (f_ri  & ~clr[6]);
      f_ru     <= set_ru         | (f_ru  & ~clr[7]);
      f_rps    <= set_rps        | (f_rps & ~clr[8]);
      f_rwt    <= set_rwt        | (f_rwt & ~clr[9]);
      f_eti    <= tx_fifo_loaded | (f_eti & ~clr[10]);
      f_fbi    <= bus_err        | (f_fbi & ~clr[13]);
      f_eri    <= !rx_frame_done && (rx_buf1_full | (f_eri & ~clr[14]));
      if (!f_fbi && bus_err) err_code <= bus_err_code;
      else if (f_fbi && clr[13] && !bus_err) err_code <= 3'd0;
    end
  end

  always_comb begin
    host_rdata        = 32'd0;
    host_rdata[6]     = f_ri;
    host_rdata[7]     = f_ru;
    host_rdata[8]     = f_rps;
    host_rdata[9]     = f_rwt;
    host_rdata[10]    = f_eti;
    host_rdata[13]    = f_fbi;
    host_rdata[14]    = f_eri;
    host_rdata[25:23] = err_code;
  end

  assign rx_state    = st;
  assign bus_disable = f_fbi;
endmodule

// File: rtl/dma_irq_status_chk.sv
module dma_irq_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_frame_done,
  input logic        rx_desc_fetch,
  input logic        rx_desc_dma_owned,
  input logic        rx_poll_demand,
  input logic        rx_frame_start,
  input logic        rx_stop,
  input logic        tx_fifo_loaded,
  input logic        bus_err,
  input logic        host_wr,
  input logic [31:0] host_wdata,
  input logic [31:0] host_rdata,
  input logic [1:0]  rx_state,
  input logic        bus_disable
);
  p_ri_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_done |=> host_rdata[6]);
  p_eri_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_done |=> !host_rdata[14]);
  p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_wdata[10] && !tx_fifo_loaded) |=> !host_rdata[10]);
  p_suspend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_state == 2'd1 && rx_desc_fetch && !rx_desc_dma_owned && !rx_stop) |=> rx_state == 2'd2);
  p_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_state == 2'd2 && (rx_poll_demand || rx_frame_start) && !rx_stop) |=> rx_state == 2'd1);
  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stop && rx_state != 2'd0) |=> (host_rdata[8] && rx_state == 2'd0));
  p_state_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_state != 2'd3);
  p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_disable |=> (!bus_disable || $stable(host_rdata[25:23])));
  p_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> bus_disable);
endmodule

bind dma_irq_status dma_irq_status_chk u_chk (.*);

// File: tb/dma_irq_status_bench.sv
`timescale 1ns/1ps
module dma_irq_status_bench;
  localparam int STD = 8;
  localparam int JMB = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_frame_done = 0, rx_buf1_full = 0, rx_desc_fetch = 0, rx_desc_dma_owned = 0;
  logic rx_poll_demand = 0, rx_frame_start = 0, rx_byte_valid = 0, rx_start = 0, rx_stop = 0;
  logic jumbo_en = 0, tx_fifo_loaded = 0, bus_err = 0, host_wr = 0;
  logic [2:0] bus_err_code = 0;
  logic [31:0] host_wdata = 0;
  logic [31:0] host_rdata;
  logic [1:0] rx_state;
  logic bus_disable;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_irq_status #(.STD_LIMIT(STD), .JUMBO_LIMIT(JMB)) u_dma_irq_status (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic quiet();
    rx_frame_done = 0; rx_buf1_full = 0; rx_desc_fetch = 0; rx_desc_dma_owned = 0;
    rx_poll_demand = 0; rx_frame_start = 0; rx_byte_valid = 0; rx_start = 0; rx_stop = 0;
    tx_fifo_loaded = 0; bus_err = 0; host_wr = 0; host_wdata = 0;
  endtask

  task automatic wr(input logic [31:0] d);
    host_wr = 1; host_wdata = d; tick(); quiet();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 rdata", host_rdata, 32'd0);
    chk("R1 state", {30'd0, rx_state}, 32'd0);
    chk("R1 disable", {31'd0, bus_disable}, 32'd0);

    rx_frame_done = 1; tick(); quiet();
    chk("R3 bit6", {31'd0, host_rdata[6]}, 1);
    tx_fifo_loaded = 1; tick(); quiet();
    chk("R3 bit10", {31'd0, host_rdata[10]}, 1);
    wr(32'd0);
    chk("R2 write zero", host_rdata & 32'h440, 32'h440);

    // R2 sweep: prior value, set event, write-one clear, for bits 6 and 10
    for (int b = 0; b < 2; b++) begin
      for (int k = 0; k < 8; k++) begin
        int bit_i;
        logic prv, st_e, cl;
        bit_i = (b == 0) ? 6 : 10;
        prv = k[2]; st_e = k[1]; cl = k[0];
        wr(32'hFFFF_FFFF);
        if (prv) begin
          if (b == 0) rx_frame_done = 1; else tx_fifo_loaded = 1;
          tick(); quiet();
        end
        if (b == 0) rx_frame_done = st_e; else tx_fifo_loaded = st_e;
        host_wr = cl; host_wdata = 32'd1 << bit_i;
        tick(); quiet();
        chk("R2 set/clear", {31'd0, host_rdata[bit_i]}, {31'd0, st_e | (prv & ~cl)});
      end
    end

    // R4 sweep: prior bit14, buffer event, frame done
    for (int k = 0; k < 8; k++) begin
      logic prv, bf, dn;
      prv = k[2]; bf = k[1]; dn = k[0];
      wr(32'hFFFF_FFFF);
      if (prv) begin rx_buf1_full = 1; tick(); quiet(); end
      rx_buf1_full = bf; rx_frame_done = dn;
      tick(); quiet();
      chk("R4 bit14", {31'd0, host_rdata[14]}, {31'd0, ~dn & (bf | prv)});
    end

    // R7 start/stop
    wr(32'hFFFF_FFFF);
    rx_stop = 1; tick(); quiet();
    chk("R7 stop while stopped no bit8", {31'd0, host_rdata[8]}, 0);
    rx_start = 1; tick(); quiet();
    chk("R7 running", {30'd0, rx_state}, 1);

    // R5/R6 descriptor ownership
    rx_desc_fetch = 1; rx_desc_dma_owned = 1; tick(); quiet();
    chk("R5 dma desc stays running", {30'd0, rx_state}, 1);
    rx_desc_fetch = 1; rx_desc_dma_owned = 0; tick(); quiet();
    chk("R5 suspended", {30'd0, rx_state}, 2);
    chk("R5 bit7 set", {31'd0, host_rdata[7]}, 1);
    rx_desc_fetch = 1; rx_desc_dma_owned = 1; tick(); quiet();
    chk("R5 fetch ignored when suspended", {30'd0, rx_state}, 2);
    rx_poll_demand = 1; tick(); quiet();
    chk("R6 poll resumes", {30'd0, rx_state}, 1);
    wr(32'h80);
    rx_desc_fetch = 1; rx_desc_dma_owned = 0; tick(); quiet();
    chk("R5 suspended again", {30'd0, rx_state}, 2);
    chk("R5 no bit7 after host desc", {31'd0, host_rdata[7]}, 0);
    rx_frame_start = 1; tick(); quiet();
    chk("R6 frame resumes", {30'd0, rx_state}, 1);
    rx_desc_fetch = 1; rx_desc_dma_owned = 1; tick(); quiet();
    rx_desc_fetch = 1; rx_desc_dma_owned = 0; tick(); quiet();
    chk("R5 bit7 after dma desc", {31'd0, host_rdata[7]}, 1);
    rx_stop = 1; rx_poll_demand = 1; tick(); quiet();
    chk("R7 stop priority", {30'd0, rx_state}, 0);
    chk("R7 bit8", {31'd0, host_rdata[8]}, 1);

    // R8 frame length sweep
    for (int j = 0; j < 2; j++) begin
      jumbo_en = j[0];
      for (int len = 0; len <= JMB + 5; len++) begin
        int lim;
        lim = j ? JMB : STD;
        wr(32'hFFFF_FFFF);
        rx_frame_start = 1; tick(); quiet();
        for (int i = 0; i < len; i++) begin rx_byte_valid = 1; tick(); quiet(); end
        chk("R8 length flag", {31'd0, host_rdata[9]}, {31'd0, len > lim});
        if (len > lim) begin
          wr(32'h200);
          repeat (3) begin rx_byte_valid = 1; tick(); quiet(); end
          chk("R8 once per frame", {31'd0, host_rdata[9]}, 0);
        end
      end
    end
    jumbo_en = 0;

    // R9/R10 bus error
    wr(32'hFFFF_FFFF);
    bus_err = 1; bus_err_code = 3'd5; tick(); quiet();
    chk("R9 bit13", {31'd0, host_rdata[13]}, 1);
    chk("R9 code", {29'd0, host_rdata[25:23]}, 5);
    chk("R10 disable", {31'd0, bus_disable}, 1);
    bus_err = 1; bus_err_code = 3'd2; tick(); quiet();
    chk("R9 code held", {29'd0, host_rdata[25:23]}, 5);
    bus_err = 1; bus_err_code = 3'd6; host_wr = 1; host_wdata = 32'h2000; tick(); quiet();
    chk("R2 set beats clear bit13", {31'd0, host_rdata[13]}, 1);
    wr(32'h2000);
    chk("R9 code cleared", {29'd0, host_rdata[25:23]}, 0);
    chk("R10 disable low", {31'd0, bus_disable}, 0);
    bus_err = 1; bus_err_code = 3'd3; tick(); quiet();
    chk("R9 new code", {29'd0, host_rdata[25:23]}, 3);

    // R11 reserved bits
    rx_frame_done = 1; tx_fifo_loaded = 1; tick(); quiet();
    rx_buf1_full = 1; tick(); quiet();
    wr(~32'h0380_67C0);
    chk("R11 reserved write", host_rdata, 32'h0180_6440);
    chk("R11 reserved zero", host_rdata & ~32'h0380_67C0, 32'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule